// File: doc/BRIEF.md
# Flash Power-Down Sequencer with Wake-Up Hold-Off

This block decides when a small controller with an embedded flash array may enter its low-power state, and when it may leave it. Software raises a one-cycle request pulse. The sequencer then asks the flash to shut down at once and gates the core clock. It waits until the flash reports that shutdown has finished, or until a timeout runs out. The timeout is long if the flash was programming or erasing when the request arrived, and short otherwise.

Wake-up events can arrive while the flash is still shutting down. Such an event is not lost, and it is not acted on early. It sets a sticky pending flag. When the shutdown window closes, the sequencer goes straight to the waking state instead of resting in power-down. In the waking state the flash power-down request is withdrawn. The sequencer then waits for the flash to report ready before it enables the core clock again. Hardware clears the request bit on the way into the waking state. A two-bit status output shows the current phase.

Top module: `pwrdn_seq`

## Requirements
- R1: After reset `pwrState` is 0 (active), `coreClkEn` is 1, and `flashPdReq` and `reqBit` are 0.
- R2: A `reqSet` pulse seen in the active state moves the block to entering (`pwrState`=1) at the next edge. From that cycle on, `flashPdReq`=1, `reqBit`=1 and `coreClkEn`=0.
- R3: The timeout is LONG_CYCLES when `flashMode` at the request cycle is 2 (program) or 3 (erase). It is SHORT_CYCLES when `flashMode` is 0 (idle) or 1 (read).
- R4: Without `flashDone` and without a wake-up, the entering state lasts exactly the selected timeout in cycles, and the block then goes to powered-down (`pwrState`=2).
- R5: `flashDone` high in an entering cycle ends the entering state at that clock edge.
- R6: A wake-up seen in any entering cycle, including the last, is held. When the entering state ends, the block goes to waking (`pwrState`=3) and never to powered-down. The entering state itself is not shortened.
- R7: In powered-down, `flashPdReq` stays 1 and the state holds until any `wakeSrc` bit is 1. The block then moves to waking at the next edge.
- R8: In waking, `flashPdReq`=0, `reqBit`=0 and `coreClkEn`=0. The state holds while `flashReady` is 0 and returns to active once `flashReady` is 1.
- R9: `pwrState` encodes 0 active, 1 entering, 2 powered-down and 3 waking. `flashPdReq` is 1 only in entering and powered-down, and `coreClkEn` is 1 only in active.
- R10: `reqSet` outside the active state has no effect, and wake-up inputs in the active state have no effect.
- R11: A change of `flashMode` during the entering state does not change the timeout already chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqSet | input | 1 | Software write pulse setting the power-down request |
| flashMode | input | 2 | Flash mode: 0 idle, 1 read, 2 program, 3 erase |
| flashDone | input | 1 | Flash reports power-down complete |
| flashReady | input | 1 | Flash reports ready after restart |
| wakeSrc | input | NUM_WAKE | Wake-up event sources, active high |
| flashPdReq | output | 1 | Request to the flash to power down |
| coreClkEn | output | 1 | Core clock enable |
| reqBit | output | 1 | Current value of the request bit |
| pwrState | output | 2 | Status: phase of the sequence |

## Verification
The assertions assume that all inputs are synchronous to `clk`, that `reqSet` and the wake-up sources are clean levels sampled at each edge, and that SHORT_CYCLES does not exceed LONG_CYCLES. The bench drives every input on the falling edge only. It keeps the timeouts small through parameter overrides, so that every timeout window can be walked cycle by cycle. Wake-up and done pulses are placed on chosen cycles of the entering window, including its first and last cycles.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_ENTER  = 2'd1,
    PS_DOWN   = 2'd2,
    PS_WAKE   = 2'd3
  } pwr_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic startSeq;   // request accepted, begin shutdown window
    logic countEn;    // shutdown window running
    logic enterWake;  // leaving to waking state
  } seq_strobe_t;

endpackage

// File: rtl/pwrdn_dp.sv
module pwrdn_dp
  import pwrdn_pkg::*;
#(
  parameter int LONG_CYCLES  = 16000,
  parameter int SHORT_CYCLES = 35,
  parameter int NUM_WAKE     = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  seq_strobe_t         stb,
  input  logic [1:0]          flashMode,
  input  logic [NUM_WAKE-1:0] wakeSrc,
  output logic                timeoutHit,
  output logic                wakeAny,
  output logic                wakePend,
  output logic                reqBit
);

  localparam int CNT_W = $clog2(LONG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYCLES - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYCLES - 1);

  logic [CNT_W-1:0] winCnt;
  logic             longSel;
  logic [CNT_W-1:0] lastCnt;

  // Mode 2/3 (program/erase) picks the long window; latched at request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      longSel <= 1'b0;
    end else if (stb.startSeq) begin
      longSel <= flashMode[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (stb.startSeq) begin
      winCnt <= '0;
    end else if (stb.countEn) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  assign lastCnt    = longSel ? LONG_LAST : SHORT_LAST;
  assign timeoutHit = stb.countEn && (winCnt == lastCnt);
  assign wakeAny    = |wakeSrc;

  // Sticky pending wake-up captured during the shutdown window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wakePend <= 1'b0;
    end else if (stb.startSeq || stb.enterWake) begin
      wakePend <= 1'b0;
    end else if (stb.countEn && wakeAny) begin
      wakePend <= 1'b1;
    end
  end

  // Request bit: set by software pulse, cleared by hardware on wake-up
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqBit <= 1'b0;
    end else if (stb.enterWake) begin
      reqBit <= 1'b0;
    end else if (stb.startSeq) begin
      reqBit <= 1'b1;
    end
  end

endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqSet,
  input  logic        flashDone,
  input  logic        flashReady,
  input  logic        timeoutHit,
  input  logic        wakeAny,
  input  logic        wakePend,
  output pwr_state_e  state,
  output seq_strobe_t stb,
  output logic        flashPdReq,
  output logic        coreClkEn
);

  pwr_state_e stateNext;
  logic       seqDone;

  assign seqDone = flashDone || timeoutHit;

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      PS_ACTIVE: begin
        if (reqSet) begin
          stateNext    = PS_ENTER;
          stb.startSeq = 1'b1;
        end
      end
      PS_ENTER: begin
        stb.countEn = 1'b1;
        if (seqDone) begin
          if (wakePend || wakeAny) begin
            stateNext     = PS_WAKE;
            stb.enterWake = 1'b1;
          end else begin
            stateNext = PS_DOWN;
          end
        end
      end
      PS_DOWN: begin
        if (wakeAny) begin
          stateNext     = PS_WAKE;
          stb.enterWake = 1'b1;
        end
      end
      PS_WAKE: begin
        if (flashReady) begin
          stateNext = PS_ACTIVE;
        end
      end
      default: stateNext = PS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= PS_ACTIVE;
    end else begin
      state <= stateNext;
    end
  end

  assign flashPdReq = (state == PS_ENTER) || (state == PS_DOWN);
  assign coreClkEn  = (state == PS_ACTIVE);

endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pwrdn_pkg::*;
#(
  parameter int LONG_CYCLES  = 16000,
  parameter int SHORT_CYCLES = 35,
  parameter int NUM_WAKE     = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqSet,
  input  logic [1:0]          flashMode,
  input  logic                flashDone,
  input  logic                flashReady,
  input  logic [NUM_WAKE-1:0] wakeSrc,
  output logic                flashPdReq,
  output logic                coreClkEn,
  output logic                reqBit,
  output logic [1:0]          pwrState
);

  seq_strobe_t stb;
  pwr_state_e  state;
  logic        timeoutHit;
  logic        wakeAny;
  logic        wakePend;

  pwrdn_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqSet     (reqSet),
    .flashDone  (flashDone),
    .flashReady (flashReady),
    .timeoutHit (timeoutHit),
    .wakeAny    (wakeAny),
    .wakePend   (wakePend),
    .state      (state),
    .stb        (stb),
    .flashPdReq (flashPdReq),
    .coreClkEn  (coreClkEn)
  );

  pwrdn_dp #(
    .LONG_CYCLES  (LONG_CYCLES),
    .SHORT_CYCLES (SHORT_CYCLES),
    .NUM_WAKE     (NUM_WAKE)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .flashMode  (flashMode),
    .wakeSrc    (wakeSrc),
    .timeoutHit (timeoutHit),
    .wakeAny    (wakeAny),
    .wakePend   (wakePend),
    .reqBit     (reqBit)
  );

  assign pwrState = state;

endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk #(
  parameter int LONG_CYCLES  = 16000,
  parameter int SHORT_CYCLES = 35,
  parameter int NUM_WAKE     = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqSet,
  input logic [1:0]          flashMode,
  input logic                flashDone,
  input logic                flashReady,
  input logic [NUM_WAKE-1:0] wakeSrc,
  input logic                flashPdReq,
  input logic                coreClkEn,
  input logic                reqBit,
  input logic [1:0]          pwrState
);

  int   enterCyc;
  logic chkLong;

  // Independent window counter and mode latch for the bound check
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enterCyc <= 0;
      chkLong  <= 1'b0;
    end else begin
      enterCyc <= (pwrState == 2'd1) ? enterCyc + 1 : 0;
      if (pwrState == 2'd0 && reqSet) chkLong <= flashMode[1];
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rstN |=> pwrState == 2'd0 && !reqBit); // R1
  AST_REQ_ENTERS: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd0 && reqSet) |=> (pwrState == 2'd1 && reqBit && flashPdReq && !coreClkEn)); // R2
  AST_ONLY_BY_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd0 && !reqSet) |=> pwrState == 2'd0); // R10
  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd1) |-> enterCyc < (chkLong ? LONG_CYCLES : SHORT_CYCLES)); // R4
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd1 && flashDone) |=> pwrState != 2'd1); // R5
  AST_HELD_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd1 && (|wakeSrc)) |=> pwrState != 2'd2 && pwrState != 2'd0); // R6
  AST_DOWN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd2 && !(|wakeSrc)) |=> pwrState == 2'd2 && flashPdReq); // R7
  AST_READY_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd3 && !flashReady) |=> pwrState == 2'd3 && !coreClkEn); // R8
  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd3) |-> (!reqBit && !flashPdReq)); // R8

endmodule

bind pwrdn_seq pwrdn_seq_chk #(
  .LONG_CYCLES  (LONG_CYCLES),
  .SHORT_CYCLES (SHORT_CYCLES),
  .NUM_WAKE     (NUM_WAKE)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .reqSet     (reqSet),
  .flashMode  (flashMode),
  .flashDone  (flashDone),
  .flashReady (flashReady),
  .wakeSrc    (wakeSrc),
  .flashPdReq (flashPdReq),
  .coreClkEn  (coreClkEn),
  .reqBit     (reqBit),
  .pwrState   (pwrState)
);

// File: tb/sim_pwrdn_seq.sv
module sim_pwrdn_seq;

  localparam int LONG  = 40;
  localparam int SHORT = 6;
  localparam int NW    = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqSet = 1'b0;
  logic [1:0]    flashMode = 2'd0;
  logic          flashDone = 1'b0;
  logic          flashReady = 1'b1;
  logic [NW-1:0] wakeSrc = '0;
  logic          flashPdReq, coreClkEn, reqBit;
  logic [1:0]    pwrState;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwrdn_seq #(.LONG_CYCLES(LONG), .SHORT_CYCLES(SHORT), .NUM_WAKE(NW)) u0 (
    .clk(clk), .rstN(rstN), .reqSet(reqSet), .flashMode(flashMode),
    .flashDone(flashDone), .flashReady(flashReady), .wakeSrc(wakeSrc),
    .flashPdReq(flashPdReq), .coreClkEn(coreClkEn), .reqBit(reqBit),
    .pwrState(pwrState)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  int mState = 0, mCnt = 0, mLim = 0;
  bit mPend = 0, mReq = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mPend = 0; mReq = 0;
    end else begin
      case (mState)
        0: if (reqSet) begin
             mState = 1; mReq = 1; mPend = 0; mCnt = 0;
             mLim = (flashMode >= 2) ? LONG : SHORT;
           end
        1: begin
             mCnt++;
             if (wakeSrc != 0) mPend = 1;
             if (flashDone || mCnt == mLim) begin
               if (mPend) begin mState = 3; mReq = 0; mPend = 0; end
               else mState = 2;
             end
           end
        2: if (wakeSrc != 0) begin mState = 3; mReq = 0; end
        default: if (flashReady) mState = 0;
      endcase
    end
  end

  // Compare against the model on every falling edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R9 status vs model", pwrState, mState);
      check("R9 flashPdReq vs model", flashPdReq, (mState == 1 || mState == 2));
      check("R9 coreClkEn vs model", coreClkEn, (mState == 0));
      check("R8 reqBit vs model", reqBit, mReq);
    end
  end

  // Request, then walk the entering window; returns its length and next state
  task automatic runEnter(input logic [1:0] mode, input int doneAt, input int wakeAt,
                          input bit chgMode, output int len, output int after);
    @(negedge clk);
    reqSet = 1'b1; flashMode = mode;
    @(negedge clk);
    reqSet = 1'b0;
    len = 0;
    while (pwrState == 2'd1 && len < 1000) begin
      flashDone = (len == doneAt);
      wakeSrc   = (len == wakeAt) ? NW'(2) : '0;
      if (chgMode) flashMode = ~mode;
      len++;
      @(negedge clk);
    end
    flashDone = 1'b0; wakeSrc = '0;
    after = pwrState;
  endtask

  task automatic wakeUp();
    wakeSrc = NW'(1);
    @(negedge clk);
    wakeSrc = '0;
    @(negedge clk);
  endtask

  int len, after;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", pwrState, 0);
    check("R1 reset clk enable", coreClkEn, 1);
    check("R1 reset pd request", flashPdReq, 0);
    check("R1 reset request bit", reqBit, 0);
    rstN = 1'b1;

    // R10: wake-up in active is ignored
    @(negedge clk); wakeSrc = '1;
    @(negedge clk); wakeSrc = '0;
    check("R10 wake in active ignored", pwrState, 0);

    // R2, R4: short window from read mode
    @(negedge clk);
    reqSet = 1'b1; flashMode = 2'd1;
    @(negedge clk);
    reqSet = 1'b0;
    check("R2 entering state", pwrState, 1);
    check("R2 request bit set", reqBit, 1);
    check("R2 clock gated", coreClkEn, 0);
    len = 1;
    while (pwrState == 2'd1 && len < 1000) begin len++; @(negedge clk); end
    check("R4 short window length", len - 1, SHORT);
    check("R4 reaches powered-down", pwrState, 2);

    // R7 hold, R10 request ignored while down
    reqSet = 1'b1;
    @(negedge clk); reqSet = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 stays powered-down", pwrState, 2);
    check("R10 req in down ignored", reqBit, 1);

    // R8: waking waits for ready
    flashReady = 1'b0;
    wakeUp();
    check("R7 wake leaves down", pwrState, 3);
    check("R8 pd request withdrawn", flashPdReq, 0);
    check("R8 request bit cleared", reqBit, 0);
    repeat (3) @(negedge clk);
    check("R8 holds without ready", pwrState, 3);
    flashReady = 1'b1;
    @(negedge clk);
    check("R8 back to active", pwrState, 0);
    check("R8 clock enabled", coreClkEn, 1);

    // R3, R11: erase mode picks long window, mode change ignored
    runEnter(2'd3, -1, -1, 1'b1, len, after);
    check("R3 erase long window", len, LONG);
    check("R11 mode change ignored", after, 2);
    wakeUp();
    flashMode = 2'd0;

    // R3: program mode also long
    runEnter(2'd2, -1, -1, 1'b0, len, after);
    check("R3 program long window", len, LONG);
    wakeUp();

    // R3: idle mode short
    runEnter(2'd0, -1, -1, 1'b0, len, after);
    check("R3 idle short window", len, SHORT);
    wakeUp();

    // R5: done at fourth cycle of long window
    runEnter(2'd3, 3, -1, 1'b0, len, after);
    check("R5 done ends window", len, 4);
    check("R5 done to powered-down", after, 2);
    wakeUp();

    // R6: early wake is held, window not shortened
    runEnter(2'd1, -1, 0, 1'b0, len, after);
    check("R6 window not shortened", len, SHORT);
    check("R6 held wake replayed", after, 3);
    @(negedge clk);
    check("R6 returns to active", pwrState, 0);

    // R6: wake on the final cycle
    runEnter(2'd0, -1, SHORT - 1, 1'b0, len, after);
    check("R6 last-cycle wake", after, 3);
    @(negedge clk);

    // R5, R6: wake with done in the same cycle
    runEnter(2'd2, 2, 2, 1'b0, len, after);
    check("R5 done with wake length", len, 3);
    check("R6 done with wake goes waking", after, 3);
    repeat (2) @(negedge clk);
    check("R8 final active", pwrState, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired state %0d expected 0", pwrState);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule